// File: doc/BRIEF.md
# Protection-key rights register controller

This block owns the 32-bit register that holds per-key access and write-disable rights for user pages, and it carries out every operation that touches that register. Four operations are issued on one request port: a read that returns the value to the register file, a write from the register file, a save of the register into a state-image word, and a restore of the register from a state image. Each request is checked against the key-enable control bit and against its selector or operand, and it is answered one cycle later with data or with an undefined-opcode or general-protection exception.

Whenever the rights value changes, the block raises a one-cycle pulse that tells the translation cache to drop its entries. A write pulses it unconditionally. A restore pulses it only when the value really changed. The block also filters writes to the control register: the key-enable bit (bit 22) cannot be set unless the feature is present. It reports an OS-enabled flag for the feature-enumeration logic.

Top module: `key_rights_ctrl`

## Requirements
- R1: After reset the rights register reads zero, key enable is clear, and `rsp_valid_o`, `flush_o`, `save_valid_o` and both exception outputs are low.
- R2: A read (op 0) or write (op 1) issued while key enable is clear answers with `exc_ud_o` set and `exc_gp_o` clear, whatever the selector and data are.
- R3: Every request is answered with `rsp_valid_o` in the cycle after it is presented. A read with key enable set and a nonzero `sel_i` answers with `exc_gp_o`. Otherwise the read returns the register on `rd_lo_o`, with `rd_hi_o` zero.
- R4: A write with key enable set answers with `exc_gp_o` when `sel_i` is nonzero or when any of bits 63:32 of `wdata_i` is set.
- R5: A write that passes its checks loads `wdata_i[31:0]` into the register and pulses `flush_o`, even when the value is unchanged.
- R6: A request answered with an exception leaves `rights_o` unchanged and raises no `flush_o`.
- R7: A restore (op 3) with `rfbm_i` clear changes nothing. With `rfbm_i` set, it loads `img_i` when `xbv_i` is set and loads zero when `xbv_i` is clear.
- R8: A restore pulses `flush_o` exactly when the new register value differs from the old one.
- R9: A save (op 2) with `rfbm_i` set presents `save_valid_o`, `save_addr_o` = `base_i` + SAVE_OFF, and `save_data_o` = the register zero-extended to 64 bits. With `rfbm_i` clear it presents no save. A save never changes the register.
- R10: On a control-register write, `cr_masked_o` equals `cr_wdata_i` with bit 22 forced to zero when `feat_i` is low. Key enable takes bit 22 of the masked value.
- R11: `os_flag_o` is high only when `feat_i` is high and key enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| feat_i | input | 1 | Protection-key feature is present |
| cr_wr_i | input | 1 | Control-register write strobe |
| cr_wdata_i | input | 32 | Control-register write value |
| cr_masked_o | output | 32 | Write value after feature masking |
| os_flag_o | output | 1 | OS-enabled feature flag |
| req_valid_i | input | 1 | Request strobe |
| req_op_i | input | 2 | 0 read, 1 write, 2 save, 3 restore |
| sel_i | input | 32 | Selector operand for read and write |
| wdata_i | input | 64 | Write operand |
| rfbm_i | input | 1 | Requested-feature mask bit for this state |
| xbv_i | input | 1 | State-valid bit of the restore image |
| img_i | input | 32 | Register value held in the restore image |
| base_i | input | 32 | Base address of the state image |
| rsp_valid_o | output | 1 | Response strobe |
| exc_ud_o | output | 1 | Undefined-opcode exception |
| exc_gp_o | output | 1 | General-protection exception |
| rd_lo_o | output | 32 | Read result, low half |
| rd_hi_o | output | 32 | Read result, high half |
| save_valid_o | output | 1 | Save word strobe |
| save_addr_o | output | 32 | Save word address |
| save_data_o | output | 64 | Save word data |
| flush_o | output | 1 | Translation-cache flush pulse |
| rights_o | output | 32 | Current rights register |

## Verification
The assertions assume that `feat_i` stays steady while requests are being checked. They also assume that a control-register write never arrives in the same cycle as a request that depends on key enable, because key enable is sampled from its register. The stimulus keeps to both assumptions. It changes `feat_i` only inside control-register write sequences and leaves an idle cycle between consecutive requests, so each response can be matched to exactly one request.

// File: rtl/key_rights_pkg.sv
package key_rights_pkg;
  typedef enum logic [1:0] {
    KR_READ    = 2'd0,
    KR_WRITE   = 2'd1,
    KR_SAVE    = 2'd2,
    KR_RESTORE = 2'd3
  } kr_op_e;
endpackage

// File: rtl/kr_ctl.sv
module kr_ctl #(
  parameter int CW     = 32,
  parameter int KE_BIT = 22
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          feat_i,
  input  logic          cr_wr_i,
  input  logic [CW-1:0] cr_wdata_i,
  output logic [CW-1:0] cr_masked_o,
  output logic          key_en_o,
  output logic          os_flag_o
);
  logic key_en_q;

  always_comb begin
    cr_masked_o = cr_wdata_i;
    if (!feat_i) cr_masked_o[KE_BIT] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      key_en_q <= 1'b0;
    else if (cr_wr_i) key_en_q <= cr_masked_o[KE_BIT];
  end

  assign key_en_o  = key_en_q;
  assign os_flag_o = feat_i & key_en_q;

  // R10
  p_mask_absent_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cr_wr_i && !feat_i) |=> !key_en_o);
endmodule

// File: rtl/kr_check.sv
module kr_check
  import key_rights_pkg::*;
#(
  parameter int RW = 32,
  parameter int DW = 64,
  parameter int SW = 32
) (
  input  logic          valid_i,
  input  kr_op_e        op_i,
  input  logic          key_en_i,
  input  logic [SW-1:0] sel_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rfbm_i,
  input  logic          xbv_i,
  input  logic [RW-1:0] img_i,
  input  logic [RW-1:0] cur_i,
  output logic          ud_o,
  output logic          gp_o,
  output logic          rd_ok_o,
  output logic          upd_o,
  output logic          force_o,
  output logic [RW-1:0] nxt_o,
  output logic          save_o
);
  always_comb begin
    ud_o    = 1'b0;
    gp_o    = 1'b0;
    rd_ok_o = 1'b0;
    upd_o   = 1'b0;
    force_o = 1'b0;
    nxt_o   = cur_i;
    save_o  = 1'b0;
    if (valid_i) begin
      unique case (op_i)
        KR_READ: begin
          if (!key_en_i)        ud_o    = 1'b1;
          else if (sel_i != '0) gp_o    = 1'b1;
          else                  rd_ok_o = 1'b1;
        end
        KR_WRITE: begin
          if (!key_en_i) ud_o = 1'b1;
          else if (sel_i != '0 || wdata_i[DW-1:RW] != '0) gp_o = 1'b1;
          else begin
            upd_o   = 1'b1;
            force_o = 1'b1;
            nxt_o   = wdata_i[RW-1:0];
          end
        end
        KR_SAVE: save_o = rfbm_i;
        KR_RESTORE: begin
          if (rfbm_i) begin
            upd_o = 1'b1;
            nxt_o = xbv_i ? img_i : '0;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/kr_store.sv
module kr_store #(
  parameter int RW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          upd_i,
  input  logic          force_i,
  input  logic [RW-1:0] nxt_i,
  output logic [RW-1:0] rights_o,
  output logic          flush_o
);
  logic [RW-1:0] rights_q;
  logic          flush_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rights_q <= '0;
      flush_q  <= 1'b0;
    end else begin
      if (upd_i) rights_q <= nxt_i;
      flush_q <= upd_i && (force_i || nxt_i != rights_q);
    end
  end

  assign rights_o = rights_q;
  assign flush_o  = flush_q;

  // R8: any change of the value is accompanied by a flush pulse
  p_flush_on_change_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rights_q != $past(rights_q)) |-> flush_o);
endmodule

// File: rtl/key_rights_ctrl.sv
module key_rights_ctrl
  import key_rights_pkg::*;
#(
  parameter int RW       = 32,
  parameter int DW       = 64,
  parameter int SW       = 32,
  parameter int AW       = 32,
  parameter int CW       = 32,
  parameter int KE_BIT   = 22,
  parameter int SAVE_OFF = 2688
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          feat_i,
  input  logic          cr_wr_i,
  input  logic [CW-1:0] cr_wdata_i,
  output logic [CW-1:0] cr_masked_o,
  output logic          os_flag_o,
  input  logic          req_valid_i,
  input  logic [1:0]    req_op_i,
  input  logic [SW-1:0] sel_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rfbm_i,
  input  logic          xbv_i,
  input  logic [RW-1:0] img_i,
  input  logic [AW-1:0] base_i,
  output logic          rsp_valid_o,
  output logic          exc_ud_o,
  output logic          exc_gp_o,
  output logic [RW-1:0] rd_lo_o,
  output logic [DW-RW-1:0] rd_hi_o,
  output logic          save_valid_o,
  output logic [AW-1:0] save_addr_o,
  output logic [DW-1:0] save_data_o,
  output logic          flush_o,
  output logic [RW-1:0] rights_o
);
  localparam logic [AW-1:0] OFF = AW'(SAVE_OFF);
  localparam int            HW  = DW - RW;

  logic          key_en;
  logic          ud, gp, rd_ok, upd, force_fl, save;
  logic [RW-1:0] nxt;

  logic          rsp_q, ud_q, gp_q, sv_q;
  logic [RW-1:0] rd_q;
  logic [AW-1:0] saddr_q;
  logic [DW-1:0] sdata_q;

  kr_ctl #(.CW(CW), .KE_BIT(KE_BIT)) i_ctl (
    .clk_i, .rst_ni, .feat_i, .cr_wr_i, .cr_wdata_i,
    .cr_masked_o, .key_en_o(key_en), .os_flag_o
  );

  kr_check #(.RW(RW), .DW(DW), .SW(SW)) i_check (
    .valid_i(req_valid_i), .op_i(kr_op_e'(req_op_i)), .key_en_i(key_en),
    .sel_i, .wdata_i, .rfbm_i, .xbv_i, .img_i, .cur_i(rights_o),
    .ud_o(ud), .gp_o(gp), .rd_ok_o(rd_ok), .upd_o(upd), .force_o(force_fl),
    .nxt_o(nxt), .save_o(save)
  );

  kr_store #(.RW(RW)) i_store (
    .clk_i, .rst_ni, .upd_i(upd), .force_i(force_fl), .nxt_i(nxt),
    .rights_o, .flush_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_q   <= 1'b0;
      ud_q    <= 1'b0;
      gp_q    <= 1'b0;
      sv_q    <= 1'b0;
      rd_q    <= '0;
      saddr_q <= '0;
      sdata_q <= '0;
    end else begin
      rsp_q   <= req_valid_i;
      ud_q    <= ud;
      gp_q    <= gp;
      sv_q    <= save;
      rd_q    <= rd_ok ? rights_o : '0;
      saddr_q <= save ? base_i + OFF : '0;
      sdata_q <= save ? {{HW{1'b0}}, rights_o} : '0;
    end
  end

  assign rsp_valid_o  = rsp_q;
  assign exc_ud_o     = ud_q;
  assign exc_gp_o     = gp_q;
  assign rd_lo_o      = rd_q;
  assign rd_hi_o      = '0;
  assign save_valid_o = sv_q;
  assign save_addr_o  = saddr_q;
  assign save_data_o  = sdata_q;

  // R2: a protection fault is only possible once key enable was set
  p_gp_needs_key_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_gp_o |-> $past(key_en));
  // R6
  p_reject_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_ud_o || exc_gp_o) |-> (rights_o == $past(rights_o) && !flush_o));
  // R9
  p_save_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_valid_o |-> (rights_o == $past(rights_o) && rsp_valid_o));
endmodule

// File: tb/test_key_rights_ctrl.sv
module test_key_rights_ctrl;
  localparam logic [31:0] BASE = 32'h0001_0000;
  localparam int          OFF  = 2688;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        feat = 1'b0;
  logic        cr_wr = 1'b0;
  logic [31:0] cr_wdata = '0;
  logic [31:0] cr_masked;
  logic        os_flag;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = '0;
  logic [31:0] sel = '0;
  logic [63:0] wdata = '0;
  logic        rfbm = 1'b0;
  logic        xbv = 1'b0;
  logic [31:0] img = '0;
  logic        rsp_valid, exc_ud, exc_gp, save_valid, flush;
  logic [31:0] rd_lo, rd_hi, save_addr, rights;
  logic [63:0] save_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  key_rights_ctrl #(.SAVE_OFF(OFF)) i_key_rights_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .feat_i(feat), .cr_wr_i(cr_wr),
    .cr_wdata_i(cr_wdata), .cr_masked_o(cr_masked), .os_flag_o(os_flag),
    .req_valid_i(req_valid), .req_op_i(req_op), .sel_i(sel), .wdata_i(wdata),
    .rfbm_i(rfbm), .xbv_i(xbv), .img_i(img), .base_i(BASE),
    .rsp_valid_o(rsp_valid), .exc_ud_o(exc_ud), .exc_gp_o(exc_gp),
    .rd_lo_o(rd_lo), .rd_hi_o(rd_hi), .save_valid_o(save_valid),
    .save_addr_o(save_addr), .save_data_o(save_data), .flush_o(flush),
    .rights_o(rights)
  );

  typedef struct {
    bit          ud, gp, sv, fl;
    logic [31:0] lo, saddr, rights;
    logic [63:0] sdata;
    string       tag;
  } exp_t;

  exp_t        q[$];
  logic [31:0] m_rights = '0;
  bit          m_ken = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: present one request, push the model's expected response
  task automatic do_req(input logic [1:0] op, input logic [31:0] s,
                        input logic [63:0] wd, input bit fm, input bit bv,
                        input logic [31:0] im, input string tag);
    exp_t e;
    logic [31:0] nv;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; sel = s; wdata = wd;
    rfbm = fm; xbv = bv; img = im;
    e = '{ud:0, gp:0, sv:0, fl:0, lo:'0, saddr:'0, rights:'0, sdata:'0, tag:tag};
    case (op)
      2'd0: if (!m_ken) e.ud = 1; else if (s != 0) e.gp = 1; else e.lo = m_rights;
      2'd1: if (!m_ken) e.ud = 1;
            else if (s != 0 || wd[63:32] != 0) e.gp = 1;
            else begin m_rights = wd[31:0]; e.fl = 1; end
      2'd2: if (fm) begin
              e.sv = 1; e.saddr = BASE + 32'(OFF); e.sdata = {32'h0, m_rights};
            end
      default: if (fm) begin
              nv = bv ? im : 32'h0;
              e.fl = (nv != m_rights);
              m_rights = nv;
            end
    endcase
    e.rights = m_rights;
    q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: compare each response against the queue head
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (q.size() > 0) begin
        exp_t e;
        bit ok;
        e = q.pop_front();
        ok = rsp_valid && exc_ud == e.ud && exc_gp == e.gp && rd_lo == e.lo &&
             rd_hi == 0 && save_valid == e.sv && flush == e.fl && rights == e.rights &&
             (!e.sv || (save_addr == e.saddr && save_data == e.sdata));
        checks++;
        if (!ok) begin
          failures++;
          $display("FAIL %s rsp=%b ud=%b gp=%b lo=%h hi=%h sv=%b addr=%h data=%h fl=%b rights=%h expected ud=%b gp=%b lo=%h sv=%b addr=%h data=%h fl=%b rights=%h",
                   e.tag, rsp_valid, exc_ud, exc_gp, rd_lo, rd_hi, save_valid, save_addr,
                   save_data, flush, rights, e.ud, e.gp, e.lo, e.sv, e.saddr, e.sdata,
                   e.fl, e.rights);
        end
      end else if (rsp_valid || flush || save_valid) begin
        checks++;
        failures++;
        $display("FAIL R3 unexpected response rsp=%b fl=%b sv=%b expected none",
                 rsp_valid, flush, save_valid);
      end
    end
  end

  task automatic cr_write(input bit f, input logic [31:0] d, input string tag);
    logic [31:0] em;
    em = d;
    if (!f) em[22] = 1'b0;
    @(negedge clk);
    feat = f; cr_wr = 1'b1; cr_wdata = d;
    #1 check(cr_masked == em, tag, "cr_masked", 64'(cr_masked), 64'(em));
    @(negedge clk);
    cr_wr = 1'b0;
    m_ken = em[22];
    check(os_flag == (f && m_ken), "R11", "os_flag", 64'(os_flag), 64'(f && m_ken));
  endtask

  initial begin
    #80000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(rights == 0 && !rsp_valid && !flush && !save_valid && !exc_ud && !exc_gp,
          "R1", "reset outputs", 64'(rights), 64'h0);
    check(os_flag == 0, "R1", "os_flag at reset", 64'(os_flag), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    do_req(2'd0, 32'h0, 64'h0, 0, 0, 32'h0, "R2");
    do_req(2'd1, 32'h5, 64'h0000_0001_0000_0003, 0, 0, 32'h0, "R2");
    do_req(2'd1, 32'h0, 64'h3, 0, 0, 32'h0, "R2");

    cr_write(1'b0, 32'h0040_0011, "R10");
    do_req(2'd1, 32'h0, 64'h3, 0, 0, 32'h0, "R10");
    cr_write(1'b1, 32'h0040_0000, "R10");

    do_req(2'd0, 32'h0, 64'h0, 0, 0, 32'h0, "R3");
    do_req(2'd1, 32'h0, 64'h0000_0000_DEAD_BEEF, 0, 0, 32'h0, "R5");
    do_req(2'd0, 32'h0, 64'h0, 0, 0, 32'h0, "R3");
    do_req(2'd0, 32'h1, 64'h0, 0, 0, 32'h0, "R3");
    do_req(2'd1, 32'h2, 64'h1, 0, 0, 32'h0, "R4");
    do_req(2'd1, 32'h0, 64'h8000_0000_0000_0001, 0, 0, 32'h0, "R4");
    do_req(2'd1, 32'h0, 64'h0000_0001_0000_0001, 0, 0, 32'h0, "R6");
    do_req(2'd1, 32'h0, 64'h0000_0000_DEAD_BEEF, 0, 0, 32'h0, "R5");

    do_req(2'd2, 32'h0, 64'h0, 1, 0, 32'h0, "R9");
    do_req(2'd2, 32'h0, 64'h0, 0, 0, 32'h0, "R9");

    do_req(2'd3, 32'h0, 64'h0, 0, 1, 32'h1234_5678, "R7");
    do_req(2'd3, 32'h0, 64'h0, 1, 1, 32'h1234_5678, "R7");
    do_req(2'd3, 32'h0, 64'h0, 1, 1, 32'h1234_5678, "R8");
    do_req(2'd2, 32'h0, 64'h0, 1, 0, 32'h0, "R9");
    do_req(2'd3, 32'h0, 64'h0, 1, 0, 32'hFFFF_FFFF, "R7");
    do_req(2'd3, 32'h0, 64'h0, 1, 0, 32'hFFFF_FFFF, "R8");

    cr_write(1'b1, 32'h0000_0000, "R10");
    do_req(2'd0, 32'h0, 64'h0, 0, 0, 32'h0, "R2");
    cr_write(1'b1, 32'h0040_0000, "R11");
    cr_write(1'b0, 32'h0040_0000, "R11");

    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule